// File: doc/BRIEF.md
# Region Usefulness Profiling Table

This block keeps per-region warm-up statistics for a prefetch confidence scheme. Each tracked code region owns a row of sixteen slots, one for each position in a prefetch stream. Every slot holds two saturating 8-bit counts: prefetches that turned out useful and prefetches that turned out useless. Update events name a region, a stream position and a useful flag, and they bump one of the two counts in that slot. Query requests name a region and a position. A query hit returns both counts, which a threshold comparator downstream consumes. A query miss returns a not-ready indication.

Regions sit in a fully associative table of 32 tags of 26 bits each, with true least-recently-used replacement. Each entry keeps a 5-bit age rank. An update to an unknown region takes the least recently used row, zeroes all 32 of its counts, and then applies the increment. Updates and query hits both make the touched row most recently used. A query miss changes nothing.

Both inputs are valid/ready streams. The update stream is never back-pressured. The query stream is held off in any cycle where an update is presented, because updates win. It is also held off while an earlier response waits on `rsp_ready`. A response appears one cycle after its query is accepted. It stays frozen until the consumer takes it with `rsp_ready`.

Top module: `region_profile_table`

## Requirements
- R1: After reset no region is held and no response is pending: `rsp_valid` is 0, `qry_ready` is 1, and a query to any region returns `rsp_hit` = 0.
- R2: An accepted update with `upd_useful` = 1 adds one to the useful count of slot (`upd_region`, `upd_pos`). With `upd_useful` = 0 it adds one to the useless count of that slot. No other slot changes.
- R3: Both counts saturate at 255. Further increments leave them at 255.
- R4: An update to a region that is not held takes the least recently used row, sets all of that row's counts to zero, stores the new tag, and then applies its increment.
- R5: A query accepted on a clock edge gives `rsp_valid` = 1 after that edge. For a held region it gives `rsp_hit` = 1 and the current useful and useless counts of the named slot.
- R6: A query to a region that is not held gives `rsp_hit` = 0 with both counts 0. It does not allocate a row and does not change the recency order.
- R7: Accepted updates and query hits make their row the most recently used. The row replaced on allocation is the one touched least recently.
- R8: While `upd_valid` is 1, `qry_ready` is 0. A query presented in that cycle is accepted no earlier than the next cycle, and it observes the update.
- R9: While `rsp_valid` = 1 and `rsp_ready` = 0, the response fields hold steady and `qry_ready` is 0.
- R10: `upd_ready` is 1 in every cycle after reset, so every presented update is taken on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update event present |
| upd_ready | output | 1 | Update accepted (always 1) |
| upd_region | input | 26 | Region tag of the update |
| upd_pos | input | 4 | Stream position of the update |
| upd_useful | input | 1 | 1: useful prefetch, 0: useless prefetch |
| qry_valid | input | 1 | Query request present |
| qry_ready | output | 1 | Query accepted this cycle |
| qry_region | input | 26 | Region tag to look up |
| qry_pos | input | 4 | Stream position to read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | 1: region held, counts valid; 0: not ready |
| rsp_useful | output | 8 | Useful count of the slot |
| rsp_useless | output | 8 | Useless count of the slot |

## Verification
A vector walk mixes updates and queries over a few regions. It includes tag zero and the all-ones tag, and it uses positions at both ends. This separates a wrong slot index or a swapped useful/useless path from a correct one. A long run of increments on one slot shows whether the counts saturate or wrap. Filling all 32 rows, refreshing the oldest with a query, and then adding a 33rd region shows whether recency follows query hits and whether allocation clears the victim row. A burst of misses followed by hits on every held row shows that misses allocate nothing. Overlapping update and query requests, and a withheld `rsp_ready`, show the stall and hold rules.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int DEF_ENTRIES = 32;
  localparam int DEF_TAG_W   = 26;
  localparam int DEF_SLOTS   = 16;
  localparam int DEF_CNT_W   = 8;

  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_UPDATE = 2'd1,
    ACC_QUERY  = 2'd2
  } access_e;
endpackage

// File: rtl/rpt_tag_cam.sv
module rpt_tag_cam #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic [IDX_W-1:0] look_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  logic [ENTRIES-1:0] live_q;
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[e] <= 1'b0;
        tag_q[e]  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        live_q[e] <= 1'b1;
        tag_q[e]  <= wr_tag;
      end
    end
    assign match[e] = live_q[e] && (tag_q[e] == look_tag);
  end

  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) begin
        look_hit = 1'b1;
        look_idx = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/rpt_lru.sv
module rpt_lru #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_q[e] <= IDX_W'(e);
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(e)) begin
          age_q[e] <= '0;
        end else if (age_q[e] < touched_age) begin
          age_q[e] <= age_q[e] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (age_q[e] == OLDEST) victim_idx = IDX_W'(e);
    end
  end
endmodule

// File: rtl/rpt_counter_bank.sv
module rpt_counter_bank #(
  parameter int ENTRIES = 32,
  parameter int SLOTS   = 16,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int POS_W  = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_clear,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [POS_W-1:0] wr_pos,
  input  logic             wr_useful,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [POS_W-1:0] rd_pos,
  output logic [CNT_W-1:0] rd_useful,
  output logic [CNT_W-1:0] rd_useless
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] row_u [ENTRIES];
  logic [CNT_W-1:0] row_n [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    logic [CNT_W-1:0] use_q  [SLOTS];
    logic [CNT_W-1:0] waste_q[SLOTS];
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(e));

    for (genvar p = 0; p < SLOTS; p++) begin : g_slot
      logic hit_slot;
      assign hit_slot = (wr_pos == POS_W'(p));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          use_q[p]   <= '0;
          waste_q[p] <= '0;
        end else if (sel) begin
          if (wr_clear) begin
            use_q[p]   <= (hit_slot &&  wr_useful) ? CNT_W'(1) : '0;
            waste_q[p] <= (hit_slot && !wr_useful) ? CNT_W'(1) : '0;
          end else if (hit_slot) begin
            if (wr_useful && use_q[p] != CNT_MAX) use_q[p] <= use_q[p] + 1'b1;
            if (!wr_useful && waste_q[p] != CNT_MAX) waste_q[p] <= waste_q[p] + 1'b1;
          end
        end
      end
    end

    assign row_u[e] = use_q[rd_pos];
    assign row_n[e] = waste_q[rd_pos];
  end

  assign rd_useful  = row_u[rd_idx];
  assign rd_useless = row_n[rd_idx];
endmodule

// File: rtl/region_profile_table.sv
module region_profile_table
  import rpt_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int TAG_W   = DEF_TAG_W,
  parameter int SLOTS   = DEF_SLOTS,
  parameter int CNT_W   = DEF_CNT_W,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int POS_W  = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [TAG_W-1:0] upd_region,
  input  logic [POS_W-1:0] upd_pos,
  input  logic             upd_useful,
  input  logic             qry_valid,
  output logic             qry_ready,
  input  logic [TAG_W-1:0] qry_region,
  input  logic [POS_W-1:0] qry_pos,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [CNT_W-1:0] rsp_useful,
  output logic [CNT_W-1:0] rsp_useless
);
  access_e          acc;
  logic [TAG_W-1:0] look_tag;
  logic             look_hit;
  logic [IDX_W-1:0] look_idx;
  logic [IDX_W-1:0] victim_idx;
  logic [IDX_W-1:0] row_idx;
  logic             alloc;
  logic             touch;
  logic [CNT_W-1:0] cur_u;
  logic [CNT_W-1:0] cur_n;

  assign upd_ready = 1'b1;
  assign qry_ready = !upd_valid && (!rsp_valid || rsp_ready);

  always_comb begin
    if (upd_valid)                   acc = ACC_UPDATE;
    else if (qry_valid && qry_ready) acc = ACC_QUERY;
    else                             acc = ACC_IDLE;
  end

  assign look_tag = (acc == ACC_UPDATE) ? upd_region : qry_region;
  assign row_idx  = look_hit ? look_idx : victim_idx;
  assign alloc    = (acc == ACC_UPDATE) && !look_hit;
  assign touch    = (acc == ACC_UPDATE) || ((acc == ACC_QUERY) && look_hit);

  rpt_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_tag (look_tag),
    .look_hit (look_hit),
    .look_idx (look_idx),
    .wr_en    (alloc),
    .wr_idx   (victim_idx),
    .wr_tag   (upd_region)
  );

  rpt_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch),
    .touch_idx  (row_idx),
    .victim_idx (victim_idx)
  );

  rpt_counter_bank #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (acc == ACC_UPDATE),
    .wr_clear   (alloc),
    .wr_idx     (row_idx),
    .wr_pos     (upd_pos),
    .wr_useful  (upd_useful),
    .rd_idx     (look_idx),
    .rd_pos     (qry_pos),
    .rd_useful  (cur_u),
    .rd_useless (cur_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_useful  <= '0;
      rsp_useless <= '0;
    end else if (acc == ACC_QUERY) begin
      rsp_valid   <= 1'b1;
      rsp_hit     <= look_hit;
      rsp_useful  <= look_hit ? cur_u : '0;
      rsp_useless <= look_hit ? cur_n : '0;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
  parameter int TAG_W = 26,
  parameter int POS_W = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic [TAG_W-1:0] upd_region,
  input logic [POS_W-1:0] upd_pos,
  input logic             upd_useful,
  input logic             qry_valid,
  input logic             qry_ready,
  input logic [TAG_W-1:0] qry_region,
  input logic [POS_W-1:0] qry_pos,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] rsp_useful,
  input logic [CNT_W-1:0] rsp_useless
);
  p_upd_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !qry_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
      && $stable(rsp_useful) && $stable(rsp_useless)));

  p_stall_on_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !qry_ready);

  p_rsp_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_ready) |=> rsp_valid);

  p_rsp_needs_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(qry_valid && qry_ready));

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_useful == '0 && rsp_useless == '0));

  p_upd_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_ready);
endmodule

bind region_profile_table rpt_checker #(
  .TAG_W(TAG_W), .POS_W(POS_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_region_profile_table.sv
module sim_region_profile_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [25:0] upd_region = '0;
  logic [3:0]  upd_pos = '0;
  logic        upd_useful = 1'b0;
  logic        qry_valid = 1'b0;
  logic        qry_ready;
  logic [25:0] qry_region = '0;
  logic [3:0]  qry_pos = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [7:0]  rsp_useful;
  logic [7:0]  rsp_useless;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  region_profile_table u0 (.*);

  // Vector: [48]=query, [47:22]=region, [21:18]=pos, [17]=useful,
  // [16]=expected hit, [15:8]=expected useful, [7:0]=expected useless.
  // Updates exercise R2; queries check R5 (hit) or R6 (miss).
  localparam int NV = 14;
  localparam bit [48:0] VEC [NV] = '{
    {1'b0, 26'h0000100, 4'd3,  1'b1, 1'b0, 8'd0, 8'd0},
    {1'b0, 26'h0000100, 4'd3,  1'b1, 1'b0, 8'd0, 8'd0},
    {1'b0, 26'h0000100, 4'd3,  1'b0, 1'b0, 8'd0, 8'd0},
    {1'b1, 26'h0000100, 4'd3,  1'b0, 1'b1, 8'd2, 8'd1},
    {1'b1, 26'h0000100, 4'd4,  1'b0, 1'b1, 8'd0, 8'd0},
    {1'b1, 26'h0000200, 4'd3,  1'b0, 1'b0, 8'd0, 8'd0},
    {1'b0, 26'h0000200, 4'd15, 1'b0, 1'b0, 8'd0, 8'd0},
    {1'b1, 26'h0000200, 4'd15, 1'b0, 1'b1, 8'd0, 8'd1},
    {1'b1, 26'h0000200, 4'd0,  1'b0, 1'b1, 8'd0, 8'd0},
    {1'b0, 26'h0000100, 4'd0,  1'b1, 1'b0, 8'd0, 8'd0},
    {1'b1, 26'h0000100, 4'd0,  1'b0, 1'b1, 8'd1, 8'd0},
    {1'b1, 26'h3FFFFFF, 4'd0,  1'b0, 1'b0, 8'd0, 8'd0},
    {1'b0, 26'h0000000, 4'd7,  1'b1, 1'b0, 8'd0, 8'd0},
    {1'b1, 26'h0000000, 4'd7,  1'b0, 1'b1, 8'd1, 8'd0}
  };

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_update(input logic [25:0] r, input logic [3:0] p, input logic u);
    @(negedge clk);
    upd_valid = 1'b1; upd_region = r; upd_pos = p; upd_useful = u;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_query(input string req, input logic [25:0] r, input logic [3:0] p,
                          input logic eh, input int eu, input int en);
    @(negedge clk);
    qry_valid = 1'b1; qry_region = r; qry_pos = p;
    @(negedge clk);
    qry_valid = 1'b0;
    check(req, "rsp_valid", int'(rsp_valid), 1);
    check(req, "rsp_hit", int'(rsp_hit), int'(eh));
    check(req, "rsp_useful", int'(rsp_useful), eu);
    check(req, "rsp_useless", int'(rsp_useless), en);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 / R10: reset state at the ports
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    check("R1", "qry_ready after reset", int'(qry_ready), 1);
    check("R10", "upd_ready", int'(upd_ready), 1);
    do_query("R1", 26'h0000100, 4'd3, 1'b0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) begin
        do_query(VEC[i][16] ? "R5" : "R6", VEC[i][47:22], VEC[i][21:18],
                 VEC[i][16], int'(VEC[i][15:8]), int'(VEC[i][7:0]));
      end else begin
        do_update(VEC[i][47:22], VEC[i][21:18], VEC[i][17]);
      end
    end

    // R8: update and query in the same cycle, update wins
    @(negedge clk);
    upd_valid = 1'b1; upd_region = 26'h0000100; upd_pos = 4'd3; upd_useful = 1'b1;
    qry_valid = 1'b1; qry_region = 26'h0000100; qry_pos = 4'd3;
    #1 check("R8", "qry_ready with update", int'(qry_ready), 0);
    @(negedge clk);
    upd_valid = 1'b0;
    check("R8", "no response while stalled", int'(rsp_valid), 0);
    #1 check("R8", "qry_ready after update", int'(qry_ready), 1);
    @(negedge clk);
    qry_valid = 1'b0;
    check("R8", "late response valid", int'(rsp_valid), 1);
    check("R8", "query sees update", int'(rsp_useful), 3);
    check("R8", "useless unchanged", int'(rsp_useless), 1);

    // R9: response held under back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    qry_valid = 1'b1; qry_region = 26'h0000200; qry_pos = 4'd15;
    @(negedge clk);
    qry_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "held rsp_valid", int'(rsp_valid), 1);
    check("R9", "held rsp_useless", int'(rsp_useless), 1);
    check("R9", "qry_ready while held", int'(qry_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9", "rsp drained", int'(rsp_valid), 0);

    // R3: saturation of both counts
    for (int i = 0; i < 260; i++) do_update(26'h0000300, 4'd1, 1'b1);
    do_query("R3", 26'h0000300, 4'd1, 1'b1, 255, 0);
    do_update(26'h0000300, 4'd1, 1'b0);
    do_query("R3", 26'h0000300, 4'd1, 1'b1, 255, 1);

    // R1: reset drops all regions
    do_reset();
    @(negedge clk);
    check("R1", "rsp_valid after second reset", int'(rsp_valid), 0);
    do_query("R1", 26'h0000100, 4'd3, 1'b0, 0, 0);

    // R7 / R4 / R6: fill, refresh oldest, allocate, evict
    for (int i = 0; i < 32; i++) do_update(26'h0001000 + 26'(i), 4'd0, 1'b1);
    do_query("R7", 26'h0001000, 4'd0, 1'b1, 1, 0);
    do_query("R6", 26'h0000999, 4'd0, 1'b0, 0, 0);
    do_update(26'h0001020, 4'd0, 1'b1);
    do_query("R7", 26'h0001001, 4'd0, 1'b0, 0, 0);
    do_query("R7", 26'h0001000, 4'd0, 1'b1, 1, 0);
    do_query("R4", 26'h0001020, 4'd0, 1'b1, 1, 0);
    do_update(26'h0001001, 4'd0, 1'b0);
    do_query("R4", 26'h0001001, 4'd0, 1'b1, 0, 1);
    do_query("R4", 26'h0001002, 4'd0, 1'b0, 0, 0);
    for (int i = 3; i < 32; i++)
      do_query("R6", 26'h0001000 + 26'(i), 4'd0, 1'b1, 1, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule